// File: doc/BRIEF.md
# Pixel Colour Palette Lookup

This block turns a narrow pixel code into a full colour. A 4-bit index arrives from the pixel store on every pixel clock, together with display-enable and the two sync strobes. The block looks the index up in a 16-entry table of 24-bit colours and returns the colour one clock later. The enable and sync strobes are delayed by the same clock, so they stay aligned with the colour. While display-enable is low the colour output is held at black.

Software owns the table. Each entry sits at its own word address inside a fixed window of the processor's address map, from 0x80400000 up to 0x8040003C. A single word store to one of those addresses replaces that entry. Stores outside the window are ignored.

After reset the table holds a grey ramp: entry i has the level i*17 in each of its three channels. The screen therefore shows defined colours before software loads its own palette.

Top module: `palette_lut`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_rgb, out_de, out_hs and out_vs are all zero.
- R2: After reset, entry i holds the grey value with red = green = blue = i*17. For example, entry 1 reads 0x111111 and entry 15 reads 0xFFFFFF.
- R3: With pix_de high, out_rgb equals the table entry at pix_index one clock later. Red is in bits [23:16], green in [15:8] and blue in [7:0].
- R4: When pix_de is low, out_rgb is 0x000000 one clock later, whatever pix_index is.
- R5: out_de, out_hs and out_vs equal pix_de, pix_hs and pix_vs delayed by exactly one clock.
- R6: A store (bus_wr_en high) whose address lies in 0x80400000..0x8040003F writes bus_wr_data[23:0] into the entry selected by address bits [5:2]. Data bits [31:24] are dropped.
- R7: A store whose address lies outside 0x80400000..0x8040003F changes no entry. Examples are 0x80400040, 0x803FFFFC and 0x00400014.
- R8: With bus_wr_en low, nothing changes in the table, whatever the address and data are.
- R9: If a store and a lookup hit the same entry in the same clock, the lookup returns the old colour. The new colour appears from the next lookup onward.
- R10: Address bits [1:0] are ignored. For example, 0x80400027 writes entry 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Word store strobe from the processor bus |
| bus_addr | input | 32 | Byte address of the store |
| bus_wr_data | input | 32 | Store data; bits [23:0] form the colour |
| pix_index | input | 4 | Pixel code from the pixel store |
| pix_de | input | 1 | Display-enable for this pixel |
| pix_hs | input | 1 | Horizontal sync for this pixel |
| pix_vs | input | 1 | Vertical sync for this pixel |
| out_rgb | output | 24 | Looked-up colour, red in the top byte |
| out_de | output | 1 | Display-enable delayed by one clock |
| out_hs | output | 1 | Horizontal sync delayed by one clock |
| out_vs | output | 1 | Vertical sync delayed by one clock |

## Verification
The hardest case to reach is a store and a lookup hitting the same entry on the same edge. The outcome depends only on the ordering of one edge, and it is invisible unless the entry is read again a clock later. The stimulus holds pix_index on an entry while a store to that entry is issued in the same cycle. It then keeps the index there for a second cycle, so the old colour and the new colour each appear once at the output. The reference model updates its own table only after it has recorded the expected colour for that cycle.

// File: rtl/palette_pkg.sv
package palette_pkg;

    // Display strobes that travel alongside each pixel
    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } pix_sync_t;

    localparam pix_sync_t SYNC_IDLE = '{de: 1'b0, hs: 1'b0, vs: 1'b0};

endpackage

// File: rtl/palette_bus_decode.sv
module palette_bus_decode #(
    parameter int ADDR_W = 32,
    parameter int IDX_W = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8040_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit_we,
    output logic [IDX_W-1:0]  hit_idx
);
    // Word-aligned window: two byte-offset bits below the entry select
    localparam int WIN_LSB = IDX_W + 2;

    logic in_window;
    logic unused_low_bits;

    assign in_window       = (bus_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
    assign hit_we          = bus_wr_en && in_window;
    assign hit_idx         = bus_addr[WIN_LSB-1:2];
    assign unused_low_bits = ^bus_addr[1:0];

    // R8: no strobe, no table write
    p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en |-> !hit_we);

endmodule

// File: rtl/palette_store.sv
module palette_store #(
    parameter int IDX_W = 4,
    parameter int CH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [3*CH_W-1:0]  wr_rgb,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [3*CH_W-1:0]  rd_rgb
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int RGB_W   = 3 * CH_W;
    localparam int CH_MAX  = (1 << CH_W) - 1;
    localparam int STEP    = CH_MAX / (ENTRIES - 1);

    logic [RGB_W-1:0] mem_q [ENTRIES];

    function automatic logic [RGB_W-1:0] grey_of(input int i);
        logic [CH_W-1:0] lvl;
        lvl = CH_W'(i * STEP);
        return {lvl, lvl, lvl};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= grey_of(i);
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_rgb;
        end
    end

    // Read sees the contents before any write on the same edge (R9)
    assign rd_rgb = mem_q[rd_idx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry_chk
        // R6: addressed entry takes the written colour
        p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> (mem_q[g] == $past(wr_rgb)));
        // R7: entries not addressed keep their colour
        p_others_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(mem_q[g]));
    end

endmodule

// File: rtl/palette_out_stage.sv
module palette_out_stage
    import palette_pkg::*;
#(
    parameter int RGB_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RGB_W-1:0] look_rgb,
    input  pix_sync_t        sync_in,
    output logic [RGB_W-1:0] rgb_q,
    output pix_sync_t        sync_q
);
    logic seen_edge_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rgb_q       <= '0;
            sync_q      <= SYNC_IDLE;
            seen_edge_q <= 1'b0;
        end else begin
            rgb_q       <= sync_in.de ? look_rgb : '0;
            sync_q      <= sync_in;
            seen_edge_q <= 1'b1;
        end
    end

    // R4: blanked pixels are black
    p_black_when_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_q.de |-> (rgb_q == '0));

    // R5: strobes lag inputs by one clock
    p_sync_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge_q |-> (sync_q == $past(sync_in)));

    // R3: an enabled pixel carries the colour looked up one clock earlier
    p_colour_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge_q && sync_q.de) |-> (rgb_q == $past(look_rgb)));

endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import palette_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W = 4,
    parameter int CH_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8040_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic [IDX_W-1:0]  pix_index,
    input  logic              pix_de,
    input  logic              pix_hs,
    input  logic              pix_vs,
    output logic [3*CH_W-1:0] out_rgb,
    output logic              out_de,
    output logic              out_hs,
    output logic              out_vs
);
    localparam int RGB_W = 3 * CH_W;

    logic             hit_we;
    logic [IDX_W-1:0] hit_idx;
    logic [RGB_W-1:0] look_rgb;
    pix_sync_t        sync_in;
    pix_sync_t        sync_q;
    logic             unused_data_hi;

    assign unused_data_hi = ^bus_wr_data[DATA_W-1:RGB_W];

    palette_bus_decode #(
        .ADDR_W(ADDR_W),
        .IDX_W(IDX_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .clk(clk),
        .rst_n(rst_n),
        .bus_wr_en(bus_wr_en),
        .bus_addr(bus_addr),
        .hit_we(hit_we),
        .hit_idx(hit_idx)
    );

    palette_store #(
        .IDX_W(IDX_W),
        .CH_W(CH_W)
    ) u_store (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(hit_we),
        .wr_idx(hit_idx),
        .wr_rgb(bus_wr_data[RGB_W-1:0]),
        .rd_idx(pix_index),
        .rd_rgb(look_rgb)
    );

    assign sync_in = '{de: pix_de, hs: pix_hs, vs: pix_vs};

    palette_out_stage #(
        .RGB_W(RGB_W)
    ) u_out (
        .clk(clk),
        .rst_n(rst_n),
        .look_rgb(look_rgb),
        .sync_in(sync_in),
        .rgb_q(out_rgb),
        .sync_q(sync_q)
    );

    assign out_de = sync_q.de;
    assign out_hs = sync_q.hs;
    assign out_vs = sync_q.vs;

endmodule

// File: tb/palette_lut_test.sv
module palette_lut_test;

    typedef struct {
        logic [23:0] rgb;
        logic        de;
        logic        hs;
        logic        vs;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wr_data = '0;
    logic [3:0]  pix_index = '0;
    logic        pix_de = 1'b0;
    logic        pix_hs = 1'b0;
    logic        pix_vs = 1'b0;
    logic [23:0] out_rgb;
    logic        out_de;
    logic        out_hs;
    logic        out_vs;

    int n_checks = 0;
    int n_fails = 0;
    bit tracking = 1'b0;
    bit finished = 1'b0;

    logic [23:0] model [16];
    exp_t        sb_q [$];

    always #5 clk = ~clk;

    palette_lut uut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wr_data(bus_wr_data),
        .pix_index(pix_index), .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs),
        .out_rgb(out_rgb), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: applies one pixel cycle plus an optional store, predicts the output
    task automatic step(input bit we, input logic [31:0] addr, input logic [31:0] data,
                        input logic [3:0] idx, input bit de, input bit hs, input bit vs,
                        input string req);
        exp_t e;
        @(negedge clk);
        bus_wr_en   = we;
        bus_addr    = addr;
        bus_wr_data = data;
        pix_index   = idx;
        pix_de      = de;
        pix_hs      = hs;
        pix_vs      = vs;
        e.rgb = de ? model[idx] : 24'h0;
        e.de  = de;
        e.hs  = hs;
        e.vs  = vs;
        e.req = req;
        sb_q.push_back(e);
        if (we && addr >= 32'h8040_0000 && addr <= 32'h8040_003F)
            model[addr[5:2]] = data[23:0];
    endtask

    task automatic idle();
        step(1'b0, 32'h0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0, "R4");
    endtask

    // Monitor: compares each result one clock after its inputs
    always @(posedge clk) begin
        if (tracking && sb_q.size() > 0) begin
            exp_t e;
            #2;
            e = sb_q.pop_front();
            check(out_rgb == e.rgb, e.req, "out_rgb", {8'h0, out_rgb}, {8'h0, e.rgb});
            check({out_de, out_hs, out_vs} == {e.de, e.hs, e.vs}, "R5", "strobes",
                  {29'h0, out_de, out_hs, out_vs}, {29'h0, e.de, e.hs, e.vs});
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = {3{8'(i * 17)}};
        repeat (3) @(negedge clk);
        check({out_rgb, out_de, out_hs, out_vs} == 27'h0, "R1", "in reset",
              {5'h0, out_rgb, out_de, out_hs, out_vs}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check({out_rgb, out_de, out_hs, out_vs} == 27'h0, "R1", "after reset",
              {5'h0, out_rgb, out_de, out_hs, out_vs}, 32'h0);
        tracking = 1'b1;

        // R2 / R3: grey ramp sweep with varied strobes
        for (int i = 0; i < 16; i++)
            step(1'b0, 32'h0, 32'h0, 4'(i), 1'b1, i[0], i[2], "R2");
        // R4: blanking hides a bright entry
        step(1'b0, 32'h0, 32'h0, 4'hF, 1'b0, 1'b1, 1'b1, "R4");
        step(1'b0, 32'h0, 32'h0, 4'h9, 1'b0, 1'b0, 1'b1, "R4");
        // R6: in-window stores, upper data bits dropped
        step(1'b1, 32'h8040_0014, 32'hAB12_3456, 4'h0, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b1, 32'h8040_0000, 32'hFF00_A0B0, 4'h5, 1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 32'h8040_003C, 32'h0012_0034, 4'h0, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 32'h0, 32'h0, 4'hF, 1'b1, 1'b0, 1'b1, "R6");
        // R7: stores outside the window
        step(1'b1, 32'h8040_0040, 32'h00DE_AD00, 4'h0, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b1, 32'h803F_FFFC, 32'h00BE_EF00, 4'h1, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b1, 32'h0040_0014, 32'h0077_7777, 4'h2, 1'b1, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 16; i++)
            step(1'b0, 32'h0, 32'h0, 4'(i), 1'b1, 1'b1, i[1], "R7");
        // R8: in-window address but no strobe
        step(1'b0, 32'h8040_0008, 32'h0055_5555, 4'h2, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 32'h0, 32'h0, 4'h2, 1'b1, 1'b0, 1'b0, "R8");
        // R9: store and lookup of entry 3 on the same edge
        step(1'b1, 32'h8040_000C, 32'h00C0_FFEE, 4'h3, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 32'h0, 32'h0, 4'h3, 1'b1, 1'b0, 1'b0, "R9");
        // R10: unaligned byte offset still hits entry 9
        step(1'b1, 32'h8040_0027, 32'h0013_5790, 4'h0, 1'b1, 1'b0, 1'b0, "R10");
        step(1'b0, 32'h0, 32'h0, 4'h9, 1'b1, 1'b0, 1'b0, "R10");
        step(1'b0, 32'h0, 32'h0, 4'h8, 1'b1, 1'b0, 1'b0, "R10");
        idle();
        idle();
        repeat (3) @(negedge clk);
        tracking = 1'b0;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule